// File: doc/BRIEF.md
# Noise-Shaped Phase Truncation Frequency Synthesizer

This block is the digital core of a direct digital frequency synthesizer. A phase register advances every enabled clock by a programmable tuning word. Before the phase is cut down to a table address, the bits that would be thrown away are fed back through a fourth-order error-feedback loop. This pushes the truncation error to high frequencies, so a small sine table gives a cleaner spectrum than plain truncation into a table 16 times larger.

The table holds one full sine period and is filled at elaboration from a computed formula. A registered, two's complement amplitude leaves the block every enabled clock, together with a flag that rises once the pipeline holds real data. The stages are the phase register, the shaper register and the registered table read. A tuning word presented at an enabled edge first shows at the output three enabled edges later.

Top module: `shaped_dds`

## Requirements
- R1: While the synchronous active-high reset is high, the next edge clears the phase register, all shaper error memory and the table output register. After that edge the sample is 0 and the valid flag is low.
- R2: At every enabled edge the phase register takes the value phase + tuning word, modulo 2^16.
- R3: At every enabled edge the shaper forms s = phase + 4·e1 − 6·e2 + 4·e3 − e4 modulo 2^16, where e1 is the newest stored error and e4 the oldest. It stores bits 15:8 of s as the table address and pushes bits 7:0 of s, read as unsigned, as the new e1. The address therefore stays within 8 steps, modulo 256, of bits 15:8 of the unshaped phase.
- R4: Table entry a, for 0 ≤ a < 256, is round(2047·sin(2πa/256)) as a 12-bit two's complement value. At each enabled edge the output register loads the entry at the current shaper address.
- R5: After reset the valid flag rises at the second enabled edge and then stays high until the next reset. A tuning word applied at an enabled edge first affects the output after the third enabled edge. For example, phase 0 with word 0x4000 gives outputs 0, 0 and then 2047.
- R6: An edge with enable low changes no state. Sample, valid flag, phase and shaper memory all hold, and the sequence continues unchanged once enable returns.
- R7: Over N enabled clocks the output completes N·word/2^16 sine periods, give or take one, so the mean output frequency is f_clk·word/2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the whole pipeline by one sample |
| fcw_i | input | 16 | Frequency tuning word added to the phase each enabled clock |
| sample_o | output | 12 | Registered two's complement sine amplitude |
| valid_o | output | 1 | High once the output carries a computed sample |

## Verification
The bench builds the block with its default parameters: a 16-bit phase, an 8-bit address, 12-bit amplitude and a fourth-order loop. With these values a large tuning word such as 0xFFFF or 0x8000 wraps the phase register every clock or two. That exercises the modular address wrap and the extreme negative and positive error sums within a few hundred samples, while small words sweep every one of the 256 table entries. The 16-bit phase also keeps the mean-frequency count short: a word of 0x0123 completes about 18 periods in 4000 clocks, which the bench counts with a hysteresis detector that the shaper jitter of at most 8 address steps cannot cross.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // Binomial coefficient n over k, for small constant arguments.
  function automatic int binom(input int n, input int k);
    int r;
    r = 1;
    for (int i = 0; i < k; i++) r = (r * (n - i)) / (i + 1);
    return r;
  endfunction

  // Feedback weight for the error delayed by j clocks (j >= 1):
  // coefficient of z^-j in 1 - (1 - z^-1)^order, sign folded in.
  function automatic int fb_coef(input int order, input int j);
    return ((j % 2) == 1) ? binom(order, j) : -binom(order, j);
  endfunction

  // Rounded sine amplitude for table slot idx of a 2^addr_w entry period.
  function automatic int sine_code(input int idx, input int addr_w, input int amp_w);
    real ang;
    real r;
    int  full;
    ang = 2.0 * 3.14159265358979323846 * real'(idx) / real'(1 << addr_w);
    full = (1 << (amp_w - 1)) - 1;
    r = real'(full) * $sin(ang);
    if (r >= 0.0) return $rtoi(r + 0.5);
    else return -$rtoi(0.5 - r);
  endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [ACC_W-1:0] fcw_i,
  output logic [ACC_W-1:0] phase_o
);

  always_ff @(posedge clk) begin
    if (rst)     phase_o <= '0;
    else if (en) phase_o <= phase_o + fcw_i;
  end

endmodule

// File: rtl/dds_ns_shaper.sv
module dds_ns_shaper #(
  parameter int ACC_W  = 16,
  parameter int ADDR_W = 8,
  parameter int ORDER  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ACC_W-1:0]  phase_i,
  output logic [ADDR_W-1:0] addr_o
);
  import dds_pkg::*;

  localparam int ERR_W = ACC_W - ADDR_W;
  // Headroom for the worst-case feedback sum (2^ORDER times the error range).
  localparam int SUM_W = ACC_W + ORDER + 2;

  logic [ERR_W-1:0] err_q [ORDER];
  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = SUM_W'(phase_i);
    for (int k = 0; k < ORDER; k++) begin
      sum = sum + SUM_W'(fb_coef(ORDER, k + 1)) * SUM_W'(err_q[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
      for (int k = 0; k < ORDER; k++) err_q[k] <= '0;
    end else if (en) begin
      addr_o   <= sum[ACC_W-1:ERR_W];
      err_q[0] <= sum[ERR_W-1:0];
      for (int k = 1; k < ORDER; k++) err_q[k] <= err_q[k-1];
    end
  end

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic signed [AMP_W-1:0] data_o
);
  import dds_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;

  logic signed [AMP_W-1:0] rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) rom[i] = AMP_W'(sine_code(i, ADDR_W, AMP_W));
  end

  always_ff @(posedge clk) begin
    if (rst)     data_o <= '0;
    else if (en) data_o <= rom[addr_i];
  end

endmodule

// File: rtl/shaped_dds.sv
module shaped_dds #(
  parameter int ACC_W  = 16,
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 12,
  parameter int ORDER  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [ACC_W-1:0]        fcw_i,
  output logic signed [AMP_W-1:0] sample_o,
  output logic                    valid_o
);

  // Phase register, shaper register, table output register.
  localparam int LATENCY = 3;
  localparam int FILL_W  = LATENCY - 1;

  logic [ACC_W-1:0]  phase_w;
  logic [ADDR_W-1:0] addr_w;
  logic [FILL_W-1:0] fill_q;

  dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .en(en), .fcw_i(fcw_i), .phase_o(phase_w)
  );

  dds_ns_shaper #(.ACC_W(ACC_W), .ADDR_W(ADDR_W), .ORDER(ORDER)) u_shp (
    .clk(clk), .rst(rst), .en(en), .phase_i(phase_w), .addr_o(addr_w)
  );

  dds_sine_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
    .clk(clk), .rst(rst), .en(en), .addr_i(addr_w), .data_o(sample_o)
  );

  generate
    if (FILL_W == 1) begin : g_fill1
      always_ff @(posedge clk) begin
        if (rst)     fill_q <= '0;
        else if (en) fill_q <= 1'b1;
      end
    end else begin : g_filln
      always_ff @(posedge clk) begin
        if (rst)     fill_q <= '0;
        else if (en) fill_q <= {fill_q[FILL_W-2:0], 1'b1};
      end
    end
  endgenerate

  assign valid_o = fill_q[FILL_W-1];

endmodule

// File: rtl/shaped_dds_chk.sv
module shaped_dds_chk #(
  parameter int ACC_W  = 16,
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 12,
  parameter int ORDER  = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic [ACC_W-1:0]        fcw_i,
  input logic [ACC_W-1:0]        phase,
  input logic [ADDR_W-1:0]       addr,
  input logic signed [AMP_W-1:0] sample_o,
  input logic                    valid_o
);

  localparam int SPAN = 1 << (ORDER - 1);

  function automatic logic near(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] ref_hi);
    logic [ADDR_W-1:0] d;
    d = a - ref_hi;
    return (int'(d) <= SPAN) || (int'(d) >= (1 << ADDR_W) - SPAN);
  endfunction

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (!valid_o && sample_o == '0 && phase == '0)); // R1

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(rst)) |-> phase == ACC_W'($past(phase) + $past(fcw_i))); // R2

  AST_ADDR_NEAR_PHASE: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(rst)) |-> near(addr, $past(phase[ACC_W-1:ACC_W-ADDR_W]))); // R3

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> valid_o); // R5

  AST_VALID_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_o) |-> $past(en)); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(sample_o) && $stable(valid_o) && $stable(phase) && $stable(addr))); // R6

endmodule

bind shaped_dds shaped_dds_chk #(
  .ACC_W(ACC_W), .ADDR_W(ADDR_W), .AMP_W(AMP_W), .ORDER(ORDER)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .fcw_i(fcw_i),
  .phase(phase_w), .addr(addr_w), .sample_o(sample_o), .valid_o(valid_o)
);

// File: tb/shaped_dds_test.sv
`timescale 1ns/1ps
module shaped_dds_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [15:0] fcw = '0;
  logic signed [11:0] sample;
  logic valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int tbl [256];
  int m_acc, m_addr, m_v1, m_v2, m_sample;
  int m_e [4];

  always #4 clk = ~clk;

  shaped_dds uut (
    .clk(clk), .rst(rst), .en(en), .fcw_i(fcw),
    .sample_o(sample), .valid_o(valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_acc = 0; m_addr = 0; m_v1 = 0; m_v2 = 0; m_sample = 0;
    for (int k = 0; k < 4; k++) m_e[k] = 0;
  endtask

  // One enabled clock of the reference, using the values held before the edge.
  task automatic model_step(input int f);
    int s;
    m_sample = tbl[m_addr];
    m_v2 = m_v1;
    m_v1 = 1;
    s = (m_acc + 4 * m_e[0] - 6 * m_e[1] + 4 * m_e[2] - m_e[3]) & 16'hFFFF;
    m_addr = (s >> 8) & 8'hFF;
    m_e[3] = m_e[2]; m_e[2] = m_e[1]; m_e[1] = m_e[0];
    m_e[0] = s & 8'hFF;
    m_acc = (m_acc + f) & 16'hFFFF;
  endtask

  // Drive at the falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic step(input logic e, input logic [15:0] f, input string req);
    en = e; fcw = f;
    @(posedge clk);
    if (e) model_step(int'(f));
    @(negedge clk);
    chk(req, int'(valid), m_v2);
    if (m_v2 != 0) chk(req, int'(sample), m_sample);
  endtask

  task automatic do_reset();
    rst = 1'b1; en = 1'b1; fcw = 16'h1111;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    chk("R1 valid low", int'(valid), 0);
    chk("R1 sample zero", int'(sample), 0);
    rst = 1'b0;
  endtask

  task automatic t_latency();
    do_reset();
    step(1'b1, 16'h0000, "R5 fill");
    chk("R5 valid after one edge", int'(valid), 0);
    step(1'b1, 16'h0000, "R5 fill");
    chk("R5 valid after two edges", int'(valid), 1);
    step(1'b1, 16'h0000, "R5 fill");
    step(1'b1, 16'h4000, "R5 word applied");
    chk("R5 first edge", int'(sample), 0);
    step(1'b1, 16'h0000, "R5 second edge");
    chk("R5 second edge", int'(sample), 0);
    step(1'b1, 16'h0000, "R5 third edge");
    chk("R5 R4 quarter wave", int'(sample), 2047);
  endtask

  task automatic t_sweep(input logic [15:0] f, input int n);
    for (int i = 0; i < n; i++) step(1'b1, f, "R2 R3 R4 model");
  endtask

  task automatic t_hold();
    int held;
    t_sweep(16'h0357, 50);
    held = int'(sample);
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 16'hABCD, "R6 idle");
      chk("R6 sample held", int'(sample), held);
      chk("R6 valid held", int'(valid), 1);
    end
    t_sweep(16'h0357, 50);
  endtask

  task automatic t_freq(input logic [15:0] f, input int n);
    int periods;
    int expect_lo;
    bit high_side;
    bit ok;
    periods = 0;
    high_side = 1'b0;
    for (int i = 0; i < n; i++) begin
      step(1'b1, f, "R7 model");
      if (valid) begin
        if (int'(sample) > 1024 && !high_side) begin
          high_side = 1'b1;
          periods++;
        end else if (int'(sample) < -1024) begin
          high_side = 1'b0;
        end
      end
    end
    expect_lo = (n * int'(f)) / 65536;
    ok = (periods >= expect_lo - 1) && (periods <= expect_lo + 1);
    chk("R7 period count", ok ? expect_lo : periods, expect_lo);
  endtask

  initial begin
    for (int i = 0; i < 256; i++)
      tbl[i] = $rtoi($floor(2047.0 * $sin(2.0 * 3.14159265358979323846 * i / 256.0) + 0.5));
    model_reset();
    @(negedge clk);
    do_reset();
    t_latency();
    t_sweep(16'h0001, 300);
    t_sweep(16'h0155, 300);
    t_sweep(16'h1234, 300);
    t_sweep(16'h7FFF, 300);
    t_sweep(16'hFFFF, 300);
    t_sweep(16'h8000, 300);
    t_hold();
    do_reset();
    t_sweep(16'h0ACE, 200);
    do_reset();
    t_freq(16'h0123, 4000);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule